// File: doc/BRIEF.md
# DMA Request Engine

This block sits between a local DMA sequencer and the coherence fabric. The sequencer hands it one transfer at a time: a read or a write, with a physical address, a byte length and a data block. The engine turns that transfer into a single coherence request message aimed at the home directory for the address, then waits for the answering response message. A data response completes a read and hands the returned block back to the sequencer. An acknowledgement completes a write.

Only one transfer is outstanding at any time. While a transfer is pending, the sequencer sees the ready line low. Responses are matched on the line address, which is the address with its in-line offset bits cleared. The line size is a parameter. A response whose line matches but whose code is unknown, or does not suit the pending kind of transfer, is flagged as a protocol error. The transfer then stays pending.

Top module: `dma_req_engine`

## Requirements
- R1: After reset, seqReady is 1 and reqValid, doneRead, doneWrite and protoErr are all 0.
- R2: A request accepted at a clock edge (seqValid and seqReady both 1) gives exactly one cycle of reqValid in the following cycle. In that cycle reqType is 4'hA for a read or 4'hB for a write, and reqAddr, reqLen and reqData equal the accepted values.
- R3: reqDest is the home directory index, taken from address bits [OFF_W +: DEST_W] (the lowest line-address bits). With the defaults these are bits [7:6].
- R4: seqReady is 0 from the cycle after acceptance until the cycle after the completing response. A seqValid raised while busy produces no reqValid.
- R5: While a read is pending, a response with code 3'd1 (data) on the matching line makes doneRead 1 for one cycle in the next cycle, with doneData equal to the response data.
- R6: While a write is pending, a response with code 3'd2 (acknowledge) on the matching line makes doneWrite 1 for one cycle in the next cycle.
- R7: A response whose line address differs from the pending one is ignored: no done pulse, no error, and seqReady stays 0.
- R8: On the matching line, a response with any code other than 1 or 2, or with the code of the other transfer kind, makes protoErr 1 for one cycle in the next cycle. The transfer stays pending.
- R9: A response that arrives while no transfer is pending has no effect on any output.
- R10: The line size LINE_BYTES (default 64, so OFF_W is 6) fixes the offset: a response address anywhere from line base to line base + 63 matches, and line base + 64 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seqValid | input | 1 | Sequencer offers a transfer |
| seqReady | output | 1 | Engine can accept a transfer |
| seqIsWrite | input | 1 | 1 for write, 0 for read |
| seqAddr | input | ADDR_W | Physical byte address |
| seqLen | input | LEN_W | Byte length |
| seqData | input | DATA_W | Data block carried by the request |
| reqValid | output | 1 | Coherence request valid (one cycle) |
| reqType | output | 4 | Request code: 4'hA read, 4'hB write |
| reqAddr | output | ADDR_W | Physical address of the request |
| reqLen | output | LEN_W | Byte length of the request |
| reqData | output | DATA_W | Data block of the request |
| reqDest | output | DEST_W | Home directory index |
| rspValid | input | 1 | Response message valid |
| rspType | input | 3 | Response code: 1 data, 2 acknowledge |
| rspAddr | input | ADDR_W | Response address |
| rspData | input | DATA_W | Response data block |
| doneRead | output | 1 | Read complete (one cycle) |
| doneWrite | output | 1 | Write complete (one cycle) |
| doneData | output | DATA_W | Data returned by the completed read |
| protoErr | output | 1 | Malformed response on the pending line |

## Verification
The hardest case to reach from the ports is a pending transfer that receives stray traffic before its real answer. Examples are a response for a neighbouring line just past the offset boundary, a response of the wrong kind, or a new sequencer offer while busy. In each case the engine must stay busy and silent, or raise only the error pulse. The random transactions are given optional detours before the completing response: a foreign-line response, a bad code and a busy-time offer. Directed cases cover the last offset of a line and the first byte of the next one.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam logic [3:0] REQ_CODE_READ  = 4'hA;
  localparam logic [3:0] REQ_CODE_WRITE = 4'hB;
  localparam logic [2:0] RSP_CODE_DATA  = 3'd1;
  localparam logic [2:0] RSP_CODE_ACK   = 3'd2;

  typedef struct packed {
    logic capture;
    logic finishRd;
    logic finishWr;
    logic flagErr;
  } dmaStrobes_t;
endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        seqValid,
  input  logic        rspValid,
  input  logic [2:0]  rspType,
  input  logic        lineMatch,
  input  logic        pendWrite,
  output logic        seqReady,
  output dmaStrobes_t strb
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t state, stateNext;

  logic rspHit;
  assign rspHit = (state == ST_BUSY) && rspValid && lineMatch;

  always_comb begin
    strb      = '0;
    stateNext = state;
    if (state == ST_IDLE) begin
      if (seqValid) begin
        strb.capture = 1'b1;
        stateNext    = ST_BUSY;
      end
    end else if (rspHit) begin
      if (rspType == RSP_CODE_DATA && !pendWrite) begin
        strb.finishRd = 1'b1;
        stateNext     = ST_IDLE;
      end else if (rspType == RSP_CODE_ACK && pendWrite) begin
        strb.finishWr = 1'b1;
        stateNext     = ST_IDLE;
      end else begin
        strb.flagErr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign seqReady = (state == ST_IDLE);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (seqValid && seqReady) |=> !seqReady); // R4
  AST_ERR_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagErr |=> !seqReady); // R8
  AST_FINISH_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finishRd || strb.finishWr) |=> seqReady); // R5
  AST_IDLE_RSP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (seqReady && !seqValid) |=> seqReady); // R9
endmodule

// File: rtl/dma_req_path.sv
module dma_req_path
  import dma_req_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int LEN_W  = 7,
  parameter int DATA_W = 64,
  parameter int DEST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobes_t       strb,
  input  logic              seqIsWrite,
  input  logic [ADDR_W-1:0] seqAddr,
  input  logic [LEN_W-1:0]  seqLen,
  input  logic [DATA_W-1:0] seqData,
  input  logic [ADDR_W-1:0] rspAddr,
  input  logic [DATA_W-1:0] rspData,
  output logic              lineMatch,
  output logic              pendWrite,
  output logic              reqValid,
  output logic [3:0]        reqType,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic [DATA_W-1:0] reqData,
  output logic [DEST_W-1:0] reqDest,
  output logic              doneRead,
  output logic              doneWrite,
  output logic [DATA_W-1:0] doneData,
  output logic              protoErr
);
  logic [ADDR_W-1:0] holdAddr;
  logic [LEN_W-1:0]  holdLen;
  logic [DATA_W-1:0] holdData;
  logic              holdWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdAddr  <= '0;
      holdLen   <= '0;
      holdData  <= '0;
      holdWrite <= 1'b0;
    end else if (strb.capture) begin
      holdAddr  <= seqAddr;
      holdLen   <= seqLen;
      holdData  <= seqData;
      holdWrite <= seqIsWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid  <= 1'b0;
      doneRead  <= 1'b0;
      doneWrite <= 1'b0;
      protoErr  <= 1'b0;
      doneData  <= '0;
    end else begin
      reqValid  <= strb.capture;
      doneRead  <= strb.finishRd;
      doneWrite <= strb.finishWr;
      protoErr  <= strb.flagErr;
      if (strb.finishRd) doneData <= rspData;
    end
  end

  assign lineMatch = (rspAddr[ADDR_W-1:OFF_W] == holdAddr[ADDR_W-1:OFF_W]);
  assign pendWrite = holdWrite;
  assign reqType   = holdWrite ? REQ_CODE_WRITE : REQ_CODE_READ;
  assign reqAddr   = holdAddr;
  assign reqLen    = holdLen;
  assign reqData   = holdData;
  assign reqDest   = holdAddr[OFF_W +: DEST_W];

  AST_REQ_FOLLOWS_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> reqValid); // R2
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (doneRead || doneWrite) |=> !(doneRead || doneWrite)); // R5
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !strb.capture) |=> $stable(reqAddr)); // R2
endmodule

// File: rtl/dma_req_engine.sv
module dma_req_engine
  import dma_req_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int DATA_W     = 64,
  parameter int DEST_W     = 2,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              seqValid,
  output logic              seqReady,
  input  logic              seqIsWrite,
  input  logic [ADDR_W-1:0] seqAddr,
  input  logic [LEN_W-1:0]  seqLen,
  input  logic [DATA_W-1:0] seqData,
  output logic              reqValid,
  output logic [3:0]        reqType,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic [DATA_W-1:0] reqData,
  output logic [DEST_W-1:0] reqDest,
  input  logic              rspValid,
  input  logic [2:0]        rspType,
  input  logic [ADDR_W-1:0] rspAddr,
  input  logic [DATA_W-1:0] rspData,
  output logic              doneRead,
  output logic              doneWrite,
  output logic [DATA_W-1:0] doneData,
  output logic              protoErr
);
  dmaStrobes_t strb;
  logic lineMatch, pendWrite;

  dma_req_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .seqValid(seqValid), .rspValid(rspValid),
    .rspType(rspType), .lineMatch(lineMatch), .pendWrite(pendWrite),
    .seqReady(seqReady), .strb(strb)
  );

  dma_req_path #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEN_W(LEN_W),
    .DATA_W(DATA_W), .DEST_W(DEST_W)
  ) i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .seqIsWrite(seqIsWrite),
    .seqAddr(seqAddr), .seqLen(seqLen), .seqData(seqData),
    .rspAddr(rspAddr), .rspData(rspData), .lineMatch(lineMatch),
    .pendWrite(pendWrite), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqData(reqData), .reqDest(reqDest),
    .doneRead(doneRead), .doneWrite(doneWrite), .doneData(doneData),
    .protoErr(protoErr)
  );
endmodule

// File: tb/test_dma_req_engine.sv
module test_dma_req_engine;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LINE   = 64;
  localparam int DATA_W = 64;
  localparam int DEST_W = 2;
  localparam int LEN_W  = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic seqValid = 1'b0, seqIsWrite = 1'b0;
  logic [ADDR_W-1:0] seqAddr = '0;
  logic [LEN_W-1:0]  seqLen = '0;
  logic [DATA_W-1:0] seqData = '0;
  logic rspValid = 1'b0;
  logic [2:0] rspType = '0;
  logic [ADDR_W-1:0] rspAddr = '0;
  logic [DATA_W-1:0] rspData = '0;
  logic seqReady, reqValid, doneRead, doneWrite, protoErr;
  logic [3:0] reqType;
  logic [ADDR_W-1:0] reqAddr;
  logic [LEN_W-1:0] reqLen;
  logic [DATA_W-1:0] reqData, doneData;
  logic [DEST_W-1:0] reqDest;

  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_req_engine i_dma_req_engine (
    .clk(clk), .rstN(rstN), .seqValid(seqValid), .seqReady(seqReady),
    .seqIsWrite(seqIsWrite), .seqAddr(seqAddr), .seqLen(seqLen), .seqData(seqData),
    .reqValid(reqValid), .reqType(reqType), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqData(reqData), .reqDest(reqDest), .rspValid(rspValid), .rspType(rspType),
    .rspAddr(rspAddr), .rspData(rspData), .doneRead(doneRead), .doneWrite(doneWrite),
    .doneData(doneData), .protoErr(protoErr)
  );

  function automatic logic [3:0] expCode(input logic w);
    return w ? 4'hB : 4'hA;
  endfunction
  function automatic logic [DEST_W-1:0] expDest(input logic [ADDR_W-1:0] a);
    return DEST_W'(a >> 6);
  endfunction
  function automatic logic [ADDR_W-1:0] lineBase(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(LINE - 1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic txn(input logic w, input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] len,
                     input logic [DATA_W-1:0] d, input logic poke, input logic stray,
                     input logic bad, input logic [ADDR_W-1:0] okAddr);
    logic [DATA_W-1:0] back;
    back = {$urandom, $urandom};
    chk("R4 ready when idle", seqReady, 1);
    seqValid = 1; seqIsWrite = w; seqAddr = a; seqLen = len; seqData = d;
    step();
    seqValid = 0;
    chk("R2 reqValid", reqValid, 1);
    chk("R2 reqType", reqType, expCode(w));
    chk("R2 reqAddr", reqAddr, a);
    chk("R2 reqLen", reqLen, len);
    chk("R2 reqData", reqData, d);
    chk("R3 reqDest", reqDest, expDest(a));
    chk("R4 busy", seqReady, 0);
    if (poke) begin
      seqValid = 1; seqAddr = a ^ 32'h1000;
      step();
      seqValid = 0;
    end else step();
    chk("R4 R2 no second request", reqValid, 0);
    if (stray) begin
      rspValid = 1; rspType = w ? 3'd2 : 3'd1; rspAddr = lineBase(a) + LINE;
      step();
      rspValid = 0;
      chk("R7 R10 foreign line no done", {doneRead, doneWrite, protoErr}, 0);
      chk("R7 still busy", seqReady, 0);
    end
    if (bad) begin
      rspValid = 1; rspAddr = a;
      rspType = ($urandom % 2) ? (w ? 3'd1 : 3'd2) : 3'(3 + $urandom % 5);
      step();
      rspValid = 0;
      chk("R8 protoErr", protoErr, 1);
      chk("R8 no done", {doneRead, doneWrite}, 0);
      chk("R8 still busy", seqReady, 0);
    end
    rspValid = 1; rspType = w ? 3'd2 : 3'd1; rspAddr = okAddr; rspData = back;
    step();
    rspValid = 0;
    if (w) begin
      chk("R6 doneWrite", doneWrite, 1);
      chk("R6 no doneRead", doneRead, 0);
    end else begin
      chk("R5 doneRead", doneRead, 1);
      chk("R5 doneData", doneData, back);
      chk("R5 no doneWrite", doneWrite, 0);
    end
    chk("R4 ready after completion", seqReady, 1);
    step();
    chk("R5 R6 done is one cycle", {doneRead, doneWrite}, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(); step();
    rstN = 1;
    step();
    chk("R1 ready", seqReady, 1);
    chk("R1 outputs quiet", {reqValid, doneRead, doneWrite, protoErr}, 0);
    rspValid = 1; rspType = 3'd1; rspAddr = 32'h40;
    step();
    rspType = 3'd6;
    step();
    rspValid = 0;
    chk("R9 idle response ignored", {doneRead, doneWrite, protoErr, reqValid}, 0);
    chk("R9 still ready", seqReady, 1);
    // R10 directed: last offset matches, next line does not
    txn(0, 32'h0000_1200, 7'd64, 64'hA5A5, 0, 1, 0, 32'h0000_123F);
    txn(1, 32'h0000_12C5, 7'd1, 64'h5A5A, 1, 1, 1, 32'h0000_12C0);
    for (int i = 0; i < 60; i++) begin
      logic [ADDR_W-1:0] a;
      a = $urandom;
      txn($urandom % 2, a, LEN_W'(1 + $urandom % 64), {$urandom, $urandom},
          $urandom % 2, $urandom % 2, $urandom % 3 == 0,
          lineBase(a) | ADDR_W'($urandom % LINE));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule